// File: doc/BRIEF.md
# Daisy-Chain LED Driver Host Sequencer

This block is the host side of a serial LED driver chain. On a start request it produces the shift clock and serial data for N daisy-chained receivers. It reads one fixed-width packet per receiver through a packet read port. The packet for the receiver farthest down the chain goes out first, and every packet goes out most significant bit first, so that each packet settles in its own receiver. The receivers latch their data when the shift clock stays quiet, so once the last bit is out the block holds the clock low for a guaranteed number of clock periods.

When the receivers take their PWM reference from the shift clock (external clock mode), the block also produces the grayscale clocks. It first waits a settling time that is set in nanoseconds. It then sends a burst of pulses with data held low. In burst mode the burst is one whole display period of `GS_TOTAL` pulses. In interleaved mode the burst is shortened by the number of data bits, because the next frame's data clocks also count toward the display period. Packet content is supplied by the surrounding logic. A busy/done pair reports each frame.

Top module: `lchain_host`

## Requirements
- R1: After reset, and at once whenever reset is asserted, `sck`, `sdo`, `busy` and `done` are all low.
- R2: A frame sends exactly `dev_count`×`PKT_W` data bits, with `dev_count` from 1 upward. `pkt_idx` starts at `dev_count`-1 and counts down to 0. Each packet goes out bit `PKT_W`-1 first. Rising edges of `sck` follow one another every 2×`HALF` system clocks with no gap at packet boundaries.
- R3: `sdo` changes only while `sck` is low, so it holds steady through every high phase of `sck`.
- R4: After the last data rising edge, `sck` stays low for at least 16×`HALF` system clocks (8 shift periods) before the next rising edge or `done`.
- R5: External burst mode (`ext_clk_mode`=1, `interleave`=0): after the latch idle and a further ceil(`GAP_NS`/`CLK_NS`) system clocks, exactly `GS_TOTAL` pulses follow with `sdo` low.
- R6: Interleaved mode (`ext_clk_mode`=1, `interleave`=1): the burst has `GS_TOTAL` − `dev_count`×`PKT_W` pulses with `sdo` low. When that difference is zero or less, no burst is sent.
- R7: Internal mode (`ext_clk_mode`=0): no pulse follows the data bits, and `done` comes after the latch idle.
- R8: `busy` rises the cycle after an accepted `start`. `done` is a one-cycle pulse in the cycle `busy` falls. A `start` while `busy` is high is ignored and neither restarts nor extends the frame.
- R9: While `busy` is low, `sck` and `sdo` are held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request, taken only while idle |
| dev_count | input | DEV_W | Number of receivers in the chain, captured at start |
| ext_clk_mode | input | 1 | 1 = receivers use the shift clock as PWM clock |
| interleave | input | 1 | 1 = shorten the burst by the data clocks of the next frame |
| pkt_idx | output | DEV_W | Index of the packet being read |
| pkt_data | input | PKT_W | Packet for receiver `pkt_idx`, combinational response |
| sdo | output | 1 | Serial data to the first receiver |
| sck | output | 1 | Shift clock to the first receiver |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest case to reach is the handover from data bits to grayscale pulses. The bench has to tell the latch idle and the settling gap apart from the pulse period, and it has to count a burst length that depends on both the chain length and the mode. The table drives chains whose data bits are below, near and above `GS_TOTAL` in interleaved mode, including one where the burst disappears altogether. For every rising edge, the monitor classes it as data or burst by its ordinal position. It measures each rise-to-rise interval, and it measures the quiet time at the handover against the separate bounds for the two modes.

// File: rtl/lchain_host.sv
module lchain_host #(
  parameter int PKT_W    = 224,
  parameter int DEV_W    = 9,
  parameter int HALF     = 2,
  parameter int GS_TOTAL = 65536,
  parameter int IDLE_PER = 8,
  parameter int CLK_NS   = 10,
  parameter int GAP_NS   = 1340
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DEV_W-1:0] dev_count,
  input  logic             ext_clk_mode,
  input  logic             interleave,
  output logic [DEV_W-1:0] pkt_idx,
  input  logic [PKT_W-1:0] pkt_data,
  output logic             sdo,
  output logic             sck,
  output logic             busy,
  output logic             done
);
  localparam int IDLE_CYC = 2 * HALF * IDLE_PER;
  localparam int GAP_CYC  = (GAP_NS + CLK_NS - 1) / CLK_NS;
  localparam int BIT_W    = $clog2(PKT_W);
  localparam int PH_W     = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int GS_W     = $clog2(GS_TOTAL + 1);
  localparam int WAIT_MAX = (IDLE_CYC > GAP_CYC) ? IDLE_CYC : GAP_CYC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_LATCH, S_GAP, S_BURST} st_t;

  st_t              st;
  logic [PH_W-1:0]  ph;
  logic             sck_q, ext_q, done_q;
  logic [BIT_W-1:0] bit_q;
  logic [DEV_W-1:0] dev_q;
  logic [WAIT_W-1:0] wcnt;
  logic [GS_W-1:0]  pcnt, burst_q;
  logic [31:0]      data_bits, burst_len;

  wire tick = (ph == PH_W'(HALF - 1));

  assign data_bits = 32'(dev_count) * 32'(PKT_W);

  always_comb begin
    if (!ext_clk_mode)
      burst_len = 32'd0;
    else if (!interleave)
      burst_len = 32'(GS_TOTAL);
    else if (data_bits < 32'(GS_TOTAL))
      burst_len = 32'(GS_TOTAL) - data_bits;
    else
      burst_len = 32'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ph      <= '0;
      sck_q   <= 1'b0;
      ext_q   <= 1'b0;
      done_q  <= 1'b0;
      bit_q   <= '0;
      dev_q   <= '0;
      wcnt    <= '0;
      pcnt    <= '0;
      burst_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          dev_q   <= dev_count - 1'b1;
          bit_q   <= '0;
          ph      <= '0;
          sck_q   <= 1'b0;
          ext_q   <= ext_clk_mode;
          burst_q <= GS_W'(burst_len);
          st      <= S_SHIFT;
        end
        S_SHIFT: begin
          ph <= tick ? '0 : ph + 1'b1;
          if (tick) begin
            sck_q <= ~sck_q;
            if (sck_q) begin
              if (bit_q == BIT_W'(PKT_W - 1)) begin
                bit_q <= '0;
                if (dev_q == '0) begin
                  st   <= S_LATCH;
                  wcnt <= '0;
                end else
                  dev_q <= dev_q - 1'b1;
              end else
                bit_q <= bit_q + 1'b1;
            end
          end
        end
        S_LATCH: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == WAIT_W'(IDLE_CYC - 1)) begin
            if (ext_q && burst_q != '0) begin
              st   <= S_GAP;
              wcnt <= '0;
            end else begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        S_GAP: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == WAIT_W'(GAP_CYC - 1)) begin
            st   <= S_BURST;
            ph   <= '0;
            pcnt <= '0;
          end
        end
        S_BURST: begin
          ph <= tick ? '0 : ph + 1'b1;
          if (tick) begin
            sck_q <= ~sck_q;
            if (sck_q) begin
              pcnt <= pcnt + 1'b1;
              if (pcnt == burst_q - 1'b1) begin
                st     <= S_IDLE;
                done_q <= 1'b1;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign pkt_idx = dev_q;
  assign sdo     = (st == S_SHIFT) ? pkt_data[BIT_W'(PKT_W - 1) - bit_q] : 1'b0;
  assign sck     = sck_q;
  assign busy    = (st != S_IDLE);
  assign done    = done_q;
endmodule

// File: rtl/lchain_host_chk.sv
module lchain_host_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic sdo,
  input logic sck,
  input logic busy,
  input logic done
);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck && !sdo));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  assert_sdo_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(sdo));
endmodule

bind lchain_host lchain_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sdo(sdo),
  .sck(sck), .busy(busy), .done(done)
);

// File: tb/lchain_host_tb.sv
`timescale 1ns/1ps
module lchain_host_tb;
  localparam int PKT_W = 224, DEV_W = 9, HALF = 2, GS_TOTAL = 1024;
  localparam int GAP_CYC = 134;
  localparam int NV = 6;
  // n, ext, interleave, expected burst pulses
  localparam int VEC [NV][4] = '{
    '{1, 0, 0, 0},
    '{3, 0, 0, 0},
    '{2, 1, 0, 1024},
    '{2, 1, 1, 576},
    '{4, 1, 1, 128},
    '{5, 1, 1, 0}
  };

  logic clk = 0, rst_n = 0, start = 0, ext_clk_mode = 0, interleave = 0;
  logic [DEV_W-1:0] dev_count = '0;
  logic [DEV_W-1:0] pkt_idx;
  logic [PKT_W-1:0] pkt_data;
  logic sdo, sck, busy, done;

  int checks = 0, errors = 0;
  int cyc = 0, rise_cnt = 0, nbits = 0, cur_n = 1;
  int last_rise = 0, last_data_rise = 0, gap_first = -1;
  int data_err = 0, per_err = 0, burst_err = 0, hold_err = 0;
  logic prev_sck = 0, prev_sdo = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  function automatic logic [PKT_W-1:0] pkt_of(int i);
    logic [PKT_W-1:0] p;
    p = {7{32'h9E3779B9 * 32'(i + 1)}};
    p[PKT_W-1 -: 6] = 6'h25;
    return p;
  endfunction

  assign pkt_data = pkt_of(int'(pkt_idx));

  lchain_host #(.PKT_W(PKT_W), .DEV_W(DEV_W), .HALF(HALF), .GS_TOTAL(GS_TOTAL),
                .IDLE_PER(8), .CLK_NS(10), .GAP_NS(1340)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_count(dev_count),
    .ext_clk_mode(ext_clk_mode), .interleave(interleave), .pkt_idx(pkt_idx),
    .pkt_data(pkt_data), .sdo(sdo), .sck(sck), .busy(busy), .done(done));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    logic [PKT_W-1:0] ep;
    if (sck && prev_sck && sdo !== prev_sdo) hold_err++;
    if (sck && !prev_sck) begin
      if (rise_cnt < nbits) begin
        ep = pkt_of(cur_n - 1 - rise_cnt / PKT_W);
        if (sdo !== ep[PKT_W - 1 - rise_cnt % PKT_W]) data_err++;
        if (rise_cnt > 0 && cyc - last_rise != 2 * HALF) per_err++;
        last_data_rise = cyc;
      end else begin
        if (rise_cnt == nbits) gap_first = cyc - last_rise;
        else if (cyc - last_rise != 2 * HALF) per_err++;
        if (sdo !== 1'b0) burst_err++;
      end
      last_rise = cyc;
      rise_cnt++;
    end
    prev_sck = sck;
    prev_sdo = sdo;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int n, input int ext, input int ilv, input int pulses);
    int t, idle_done, rises_end;
    string mtag;
    @(negedge clk);
    rise_cnt = 0; data_err = 0; per_err = 0; burst_err = 0; hold_err = 0;
    gap_first = -1; cur_n = n; nbits = n * PKT_W;
    dev_count = DEV_W'(n); ext_clk_mode = ext[0]; interleave = ilv[0];
    start = 1;
    @(negedge clk) start = 0;
    @(negedge clk);
    chk(busy === 1'b1, "R8 busy after start", busy, 1);
    repeat (300) @(negedge clk);
    start = 1;  // ignored while busy
    @(negedge clk) start = 0;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(t < 20000, "R8 done reached", t, 20000);
    chk(busy === 1'b0, "R8 busy falls with done", busy, 0);
    idle_done = cyc - last_data_rise;
    rises_end = rise_cnt;
    mtag = (ext == 0) ? "R7 pulse total" : (ilv == 0) ? "R5 pulse total" : "R6 pulse total";
    chk(rise_cnt == nbits + pulses, mtag, rise_cnt, nbits + pulses);
    chk(data_err == 0, "R2 data order", data_err, 0);
    chk(per_err == 0, "R2 edge period", per_err, 0);
    chk(hold_err == 0, "R3 sdo steady in high phase", hold_err, 0);
    if (pulses > 0) begin
      chk(gap_first >= 16 * HALF + GAP_CYC, "R5 latch idle and settle gap", gap_first, 16 * HALF + GAP_CYC);
      chk(burst_err == 0, "R5 sdo low in burst", burst_err, 0);
    end else
      chk(idle_done >= 16 * HALF, "R4 latch idle before done", idle_done, 16 * HALF);
    repeat (40) @(negedge clk);
    chk(busy === 1'b0 && rise_cnt == rises_end, "R8 ignored start did not restart", rise_cnt, rises_end);
    chk(sck === 1'b0 && sdo === 1'b0, "R9 lines low when idle", {sck, sdo}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sck === 0 && sdo === 0 && busy === 0 && done === 0, "R1 reset state",
        {sck, sdo, busy, done}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
    // reset in the middle of a frame
    dev_count = DEV_W'(2); ext_clk_mode = 1; interleave = 0;
    start = 1;
    @(negedge clk) start = 0;
    repeat (123) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(sck === 0 && sdo === 0 && busy === 0 && done === 0, "R1 reset mid frame",
        {sck, sdo, busy, done}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_vec(1, 1, 1, 800);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule